// File: doc/BRIEF.md
# PCI Target Delayed I/O Write Controller

This block is the target-side state machine on a PCI bus segment that turns a single-beat I/O write into a delayed transaction. When the local side asks for delayed handling, the first I/O write is captured, meaning its command, address, data and byte enables. The block ends that transaction with a retry and hands the captured request to the local side in a one-cycle push. The PCI master must then repeat the identical request until the local side reports that it has drained the write.

While the request is outstanding, every claimed access is retried. This covers memory, I/O and configuration space. Once the local side signals the drain, the next repeat that matches the stored request in every field is finished with target ready and stop asserted together, which is a disconnect with data. After that the block is free again. When delayed handling is off and nothing is outstanding, an I/O write is accepted at once and still forwarded.

Top module: `pci_dw_target`

## Requirements
- R1: A synchronous active-high reset drives devsel_n, trdy_n and stop_n high and dw_push low, and discards any outstanding request. After reset, a repeat of the old write is captured anew with a retry and a push.
- R2: An address phase is a cycle where frame_n is sampled low after being high. The command is on cbe_n: I/O write 4'b0011, I/O read 4'b0010, memory read 4'b0110, memory write 4'b0111, configuration read 4'b1010, configuration write 4'b1011. With nothing outstanding only an I/O write is claimed. While a request is outstanding all six are claimed. devsel_n goes low in the cycle after the address phase, and an unclaimed command leaves all outputs high.
- R3: With defer_en high and nothing outstanding, an I/O write whose data phase is sampled with irdy_n low gets stop_n low and trdy_n high in the next cycle, for exactly one cycle. After that, devsel_n, trdy_n and stop_n return high.
- R4: In the cycle the first response appears, dw_push is high for one cycle. dw_cmd, dw_addr, dw_data and dw_be_n then carry the command, address, data and active-low byte enables of that write.
- R5: While a request is outstanding and no drain has been reported, every claimed access is retried, including an exact repeat, and dw_push stays low.
- R6: After an lcl_drained pulse, an I/O write equal to the stored request in command, address, data and byte enables gets trdy_n and stop_n low together for one cycle, without a push.
- R7: After the drain, an I/O write that differs from the stored request in data or in byte enables is still retried.
- R8: After the disconnect with data nothing is outstanding. A following memory read is not claimed, and a following deferred I/O write is captured and pushed as new.
- R9: With defer_en low and nothing outstanding, an I/O write gets trdy_n and stop_n low together at once and is pushed.
- R10: An lcl_drained pulse while nothing is outstanding has no effect. A later deferred write is retried rather than completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock; all sampling on rising edges |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Bus cycle frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad | input | 32 | Multiplexed address/data |
| cbe_n | input | 4 | Command in address phase, active-low byte enables in data phase |
| devsel_n | output | 1 | Device select, active low, registered |
| trdy_n | output | 1 | Target ready, active low, registered |
| stop_n | output | 1 | Stop, active low, registered |
| defer_en | input | 1 | Local side asks for delayed handling of I/O writes |
| lcl_drained | input | 1 | One-cycle pulse: local side has emptied its write FIFO |
| dw_push | output | 1 | One-cycle strobe: captured request is valid |
| dw_cmd | output | 4 | Captured command |
| dw_addr | output | 32 | Captured address |
| dw_data | output | 32 | Captured write data |
| dw_be_n | output | 4 | Captured byte enables, active low |

## Verification
The bench goes after three things. The first is an exact repeat of the write before any drain: a block that completes too early would assert trdy_n here and lose the ordering against the local side. The second is a repeat after the drain that differs only in data or only in byte enables: a compare that skips a field would accept the wrong write as the completion. The third is the bench also sending a drain pulse with nothing outstanding and resetting with a request pending. A block that remembered either event would finish the next deferred write with a disconnect at once, where it should retry and push.

// File: rtl/pci_dw_pkg.sv
package pci_dw_pkg;

  localparam int CMD_W = 4;

  localparam logic [CMD_W-1:0] CMD_IO_RD  = 4'b0010;
  localparam logic [CMD_W-1:0] CMD_IO_WR  = 4'b0011;
  localparam logic [CMD_W-1:0] CMD_MEM_RD = 4'b0110;
  localparam logic [CMD_W-1:0] CMD_MEM_WR = 4'b0111;
  localparam logic [CMD_W-1:0] CMD_CFG_RD = 4'b1010;
  localparam logic [CMD_W-1:0] CMD_CFG_WR = 4'b1011;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_RESP = 2'd2
  } dw_state_e;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_RETRY = 2'd1,
    RSP_DISC  = 2'd2
  } dw_resp_e;

endpackage

// File: rtl/dw_cmd_decode.sv
module dw_cmd_decode
  import pci_dw_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  output logic             is_iowr,
  output logic             is_space
);

  localparam int NCMD = 1 << CMD_W;
  localparam logic [CMD_W-1:0] SPACE_LIST [6] = '{
    CMD_IO_RD, CMD_IO_WR, CMD_MEM_RD, CMD_MEM_WR, CMD_CFG_RD, CMD_CFG_WR
  };

  logic [NCMD-1:0] space_mask;

  always_comb begin
    space_mask = '0;
    for (int i = 0; i < 6; i++) begin
      space_mask[SPACE_LIST[i]] = 1'b1;
    end
  end

  assign is_space = space_mask[cmd];
  assign is_iowr  = (cmd == CMD_IO_WR);

endmodule

// File: rtl/dw_req_store.sv
module dw_req_store #(
  parameter int AD_W = 32,
  parameter int CMD_W = 4,
  localparam int BE_W = AD_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CMD_W-1:0] in_cmd,
  input  logic [AD_W-1:0]  in_addr,
  input  logic [AD_W-1:0]  in_data,
  input  logic [BE_W-1:0]  in_be_n,
  output logic [CMD_W-1:0] q_cmd,
  output logic [AD_W-1:0]  q_addr,
  output logic [AD_W-1:0]  q_data,
  output logic [BE_W-1:0]  q_be_n,
  output logic             match
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_cmd  <= '0;
      q_addr <= '0;
      q_data <= '0;
      q_be_n <= '1;
    end else if (load) begin
      q_cmd  <= in_cmd;
      q_addr <= in_addr;
      q_data <= in_data;
      q_be_n <= in_be_n;
    end
  end

  logic cmd_eq, addr_eq, data_eq, be_eq;
  assign cmd_eq  = (q_cmd  == in_cmd);
  assign addr_eq = (q_addr == in_addr);
  assign data_eq = (q_data == in_data);
  assign be_eq   = (q_be_n == in_be_n);
  assign match   = cmd_eq & addr_eq & data_eq & be_eq;

endmodule

// File: rtl/dw_pend_track.sv
module dw_pend_track (
  input  logic clk,
  input  logic rst,
  input  logic set_pend,
  input  logic clr_pend,
  input  logic drained,
  output logic pending,
  output logic done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      done    <= 1'b0;
    end else if (clr_pend) begin
      pending <= 1'b0;
      done    <= 1'b0;
    end else if (set_pend) begin
      pending <= 1'b1;
      done    <= 1'b0;
    end else if (pending && drained) begin
      done    <= 1'b1;
    end
  end

  // R10
  no_idle_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (!pending && !set_pend) |=> !done);

  // R6
  done_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> pending);

endmodule

// File: rtl/dw_tgt_fsm.sv
module dw_tgt_fsm
  import pci_dw_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     frame_n,
  input  logic     irdy_n,
  input  logic     claim,
  input  dw_resp_e resp,
  output logic     addr_ph,
  output logic     data_ph,
  output logic     devsel_n,
  output logic     trdy_n,
  output logic     stop_n
);

  dw_state_e state;
  logic      frame_q;

  assign addr_ph = (state == ST_IDLE) && frame_q && !frame_n;
  assign data_ph = (state == ST_DATA) && !irdy_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      frame_q  <= 1'b1;
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      stop_n   <= 1'b1;
    end else begin
      frame_q <= frame_n;
      unique case (state)
        ST_IDLE: begin
          if (addr_ph && claim) begin
            state    <= ST_DATA;
            devsel_n <= 1'b0;
          end
        end
        ST_DATA: begin
          if (data_ph) begin
            state  <= ST_RESP;
            stop_n <= (resp == RSP_NONE);
            trdy_n <= (resp != RSP_DISC);
          end
        end
        ST_RESP: begin
          state    <= ST_IDLE;
          devsel_n <= 1'b1;
          trdy_n   <= 1'b1;
          stop_n   <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  trdy_with_stop_chk: assert property (@(posedge clk) disable iff (rst)
    !trdy_n |-> !stop_n);

  // R2
  stop_needs_devsel_chk: assert property (@(posedge clk) disable iff (rst)
    !stop_n |-> !devsel_n);

  // R3
  stop_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !stop_n |=> (stop_n && devsel_n));

endmodule

// File: rtl/pci_dw_target.sv
module pci_dw_target
  import pci_dw_pkg::*;
#(
  parameter int AD_W = 32,
  localparam int BE_W = AD_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic [AD_W-1:0]  ad,
  input  logic [BE_W-1:0]  cbe_n,
  output logic             devsel_n,
  output logic             trdy_n,
  output logic             stop_n,
  input  logic             defer_en,
  input  logic             lcl_drained,
  output logic             dw_push,
  output logic [CMD_W-1:0] dw_cmd,
  output logic [AD_W-1:0]  dw_addr,
  output logic [AD_W-1:0]  dw_data,
  output logic [BE_W-1:0]  dw_be_n
);

  logic             addr_ph, data_ph;
  logic             live_iowr, live_space;
  logic             cur_iowr, cur_space;
  logic             pending, done, match;
  logic             claim, set_pend, clr_pend, load;
  logic [CMD_W-1:0] cur_cmd;
  logic [AD_W-1:0]  cur_addr;
  dw_resp_e         resp;

  // Decode of the command on the bus during the address phase
  dw_cmd_decode u_live_dec (
    .cmd      (cbe_n[CMD_W-1:0]),
    .is_iowr  (live_iowr),
    .is_space (live_space)
  );

  // Decode of the command held for the data phase
  dw_cmd_decode u_cur_dec (
    .cmd      (cur_cmd),
    .is_iowr  (cur_iowr),
    .is_space (cur_space)
  );

  assign claim = live_space && (pending || live_iowr);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_cmd  <= '0;
      cur_addr <= '0;
    end else if (addr_ph) begin
      cur_cmd  <= cbe_n[CMD_W-1:0];
      cur_addr <= ad;
    end
  end

  // Response decision in the data phase
  always_comb begin
    resp     = RSP_NONE;
    set_pend = 1'b0;
    clr_pend = 1'b0;
    load     = 1'b0;
    if (data_ph && cur_space) begin
      if (pending) begin
        if (done && cur_iowr && match) begin
          resp     = RSP_DISC;
          clr_pend = 1'b1;
        end else begin
          resp = RSP_RETRY;
        end
      end else if (cur_iowr) begin
        load = 1'b1;
        if (defer_en) begin
          resp     = RSP_RETRY;
          set_pend = 1'b1;
        end else begin
          resp = RSP_DISC;
        end
      end
    end
  end

  dw_req_store #(.AD_W(AD_W), .CMD_W(CMD_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .in_cmd  (cur_cmd),
    .in_addr (cur_addr),
    .in_data (ad),
    .in_be_n (cbe_n),
    .q_cmd   (dw_cmd),
    .q_addr  (dw_addr),
    .q_data  (dw_data),
    .q_be_n  (dw_be_n),
    .match   (match)
  );

  dw_pend_track u_pend (
    .clk      (clk),
    .rst      (rst),
    .set_pend (set_pend),
    .clr_pend (clr_pend),
    .drained  (lcl_drained),
    .pending  (pending),
    .done     (done)
  );

  dw_tgt_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .claim    (claim),
    .resp     (resp),
    .addr_ph  (addr_ph),
    .data_ph  (data_ph),
    .devsel_n (devsel_n),
    .trdy_n   (trdy_n),
    .stop_n   (stop_n)
  );

  always_ff @(posedge clk) begin
    if (rst) dw_push <= 1'b0;
    else     dw_push <= load;
  end

  // R4
  push_single_chk: assert property (@(posedge clk) disable iff (rst)
    dw_push |=> !dw_push);

  // R5
  retry_while_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (data_ph && pending && !done) |=> (trdy_n && !dw_push));

  // R4
  push_with_resp_chk: assert property (@(posedge clk) disable iff (rst)
    dw_push |-> !stop_n);

endmodule

// File: tb/pci_dw_target_tb_top.sv
module pci_dw_target_tb_top;

  localparam int AD_W = 32;
  localparam int BE_W = AD_W / 8;

  logic            clk = 1'b0;
  logic            rst;
  logic            frame_n, irdy_n, defer_en, lcl_drained;
  logic [AD_W-1:0] ad;
  logic [BE_W-1:0] cbe_n;
  logic            devsel_n, trdy_n, stop_n, dw_push;
  logic [3:0]      dw_cmd;
  logic [AD_W-1:0] dw_addr, dw_data;
  logic [BE_W-1:0] dw_be_n;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  pci_dw_target #(.AD_W(AD_W)) dut_i (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n),
    .ad(ad), .cbe_n(cbe_n), .devsel_n(devsel_n), .trdy_n(trdy_n),
    .stop_n(stop_n), .defer_en(defer_en), .lcl_drained(lcl_drained),
    .dw_push(dw_push), .dw_cmd(dw_cmd), .dw_addr(dw_addr),
    .dw_data(dw_data), .dw_be_n(dw_be_n)
  );

  // {cmd4, addr32, data32, be_n4, defer, drain_before, claim, resp2, push}
  // resp: 0 none, 1 retry, 2 disconnect with data
  localparam int NV = 12;
  localparam logic [77:0] VEC [NV] = '{
    {4'b0110, 32'h0000_3000, 32'h0000_0000, 4'h0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0}, // R2 idle mem read
    {4'b0011, 32'h0000_1000, 32'hDEAD_BEEF, 4'h0, 1'b1, 1'b1, 1'b1, 2'd1, 1'b1}, // R10 R3 R4
    {4'b0011, 32'h0000_1000, 32'hDEAD_BEEF, 4'h0, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0}, // R5 exact repeat
    {4'b0111, 32'h0000_2000, 32'h1234_5678, 4'h0, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0}, // R5 mem write
    {4'b1010, 32'h0000_0010, 32'h0000_0000, 4'h0, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0}, // R2 R5 cfg read
    {4'b0011, 32'h0000_1000, 32'hDEAD_BEEE, 4'h0, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0}, // R7 data differs
    {4'b0011, 32'h0000_1000, 32'hDEAD_BEEF, 4'h3, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0}, // R7 be differs
    {4'b0011, 32'h0000_1000, 32'hDEAD_BEEF, 4'h0, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0}, // R6 match
    {4'b0110, 32'h0000_3000, 32'h0000_0000, 4'h0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0}, // R8 not claimed
    {4'b0011, 32'h0000_1004, 32'hCAFE_0001, 4'h1, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1}, // R9 immediate
    {4'b0011, 32'h0000_1008, 32'h5555_AAAA, 4'h2, 1'b1, 1'b0, 1'b1, 2'd1, 1'b1}, // R8 new capture
    {4'b0011, 32'h0000_1008, 32'h5555_AAAA, 4'h2, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0}  // R6 complete
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drain_pulse();
    @(negedge clk) lcl_drained = 1'b1;
    @(negedge clk) lcl_drained = 1'b0;
  endtask

  task automatic txn(input logic [3:0] cmd, input logic [31:0] addr,
                     input logic [31:0] data, input logic [3:0] be_n,
                     input bit exp_claim, input int exp_resp, input bit exp_push,
                     input string req);
    @(negedge clk);
    frame_n = 1'b0; ad = addr; cbe_n = cmd;
    @(negedge clk);
    chk(devsel_n == !exp_claim, req, "devsel_n", 32'(devsel_n), 32'(!exp_claim));
    frame_n = 1'b1; irdy_n = 1'b0; ad = data; cbe_n = be_n;
    @(negedge clk);
    chk(stop_n == (exp_resp == 0), req, "stop_n", 32'(stop_n), 32'(exp_resp == 0));
    chk(trdy_n == (exp_resp != 2), req, "trdy_n", 32'(trdy_n), 32'(exp_resp != 2));
    chk(dw_push == exp_push, req, "dw_push", 32'(dw_push), 32'(exp_push));
    if (exp_push) begin
      chk(dw_addr == addr, "R4", "dw_addr", dw_addr, addr);
      chk(dw_data == data, "R4", "dw_data", dw_data, data);
      chk(dw_cmd == cmd, "R4", "dw_cmd", 32'(dw_cmd), 32'(cmd));
      chk(dw_be_n == be_n, "R4", "dw_be_n", 32'(dw_be_n), 32'(be_n));
    end
    @(negedge clk);
    chk({devsel_n, trdy_n, stop_n, dw_push} == 4'b1110, "R3", "release",
        32'({devsel_n, trdy_n, stop_n, dw_push}), 32'hE);
    irdy_n = 1'b1; ad = '0; cbe_n = '0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst = 1'b1; frame_n = 1'b1; irdy_n = 1'b1; ad = '0; cbe_n = '0;
    defer_en = 1'b1; lcl_drained = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({devsel_n, trdy_n, stop_n, dw_push} == 4'b1110, "R1", "reset outputs",
        32'({devsel_n, trdy_n, stop_n, dw_push}), 32'hE);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      defer_en = VEC[i][5];
      if (VEC[i][4]) drain_pulse();
      txn(VEC[i][77:74], VEC[i][73:42], VEC[i][41:10], VEC[i][9:6],
          VEC[i][3], int'(VEC[i][2:1]), VEC[i][0], $sformatf("vec%0d", i));
    end

    // R1: reset with a drained request outstanding discards it
    defer_en = 1'b1;
    txn(4'b0011, 32'h0000_2200, 32'h0BAD_F00D, 4'h0, 1'b1, 1, 1'b1, "R1 setup");
    drain_pulse();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;
    chk({devsel_n, trdy_n, stop_n, dw_push} == 4'b1110, "R1", "outputs after reset",
        32'({devsel_n, trdy_n, stop_n, dw_push}), 32'hE);
    txn(4'b0110, 32'h0000_3000, 32'h0, 4'h0, 1'b0, 0, 1'b0, "R1 no pending");
    txn(4'b0011, 32'h0000_2200, 32'h0BAD_F00D, 4'h0, 1'b1, 1, 1'b1, "R1 fresh capture");

    // R2: I/O read while nothing outstanding is not claimed
    drain_pulse();
    txn(4'b0011, 32'h0000_2200, 32'h0BAD_F00D, 4'h0, 1'b1, 2, 1'b0, "R6 finish");
    txn(4'b0010, 32'h0000_2200, 32'h0, 4'h0, 1'b0, 0, 1'b0, "R2 io read idle");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule